// File: doc/BRIEF.md
# Per-Bit-Plane Refresh Command Gater

This block sits between the periodic refresh scheduler of a memory controller and a storage array. The array is split into one subarray per bit position of the stored word. The scheduler sends a single base refresh pulse once per base retention period. For every subarray, the block decides whether to pass that pulse through or drop it. As a result, each bit plane is refreshed once every k base pulses, where k is a multiplier held for that plane. The block never changes the base timer. It only skips commands.

Software loads one multiplier per plane through a small register port. Planes that hold more significant bits are normally given smaller multipliers, so they are refreshed more often. Less significant planes get larger multipliers and use less refresh energy. The block also keeps a saturating running count of all per-plane refreshes it has issued. This count is proportional to refresh power.

Top module: `refresh_plane_gater`

## Requirements
- R1: Synchronous active-low reset sets every multiplier to 1, every countdown to 1, `refresh_en` to 0 and `refresh_total` to 0.
- R2: The first base pulse after reset asserts all bits of `refresh_en`.
- R3: Count from reset, with base pulses that do not overlap writes to the plane's multiplier. A plane with multiplier k is enabled on the 1st, (1+k)th, (1+2k)th… base pulse. Over N pulses it therefore receives ceil(N/k) refreshes.
- R4: `refresh_en` bits are high only in the cycle right after a clock edge that sampled `base_pulse` high, and never at any other time.
- R5: A write with `cfg_addr` = i (0..7) and a nonzero `cfg_wdata` stores the multiplier of plane i. Plane 0 holds the least significant bit and plane 7 the most significant bit.
- R6: A write of 0 to a multiplier address is ignored, and the previous multiplier is kept.
- R7: A changed multiplier is used only at the plane's next reload. The countdown already running finishes with its old length, so no refresh is lost or duplicated.
- R8: `refresh_total` updates on the same edge as `refresh_en`. It grows by the number of `refresh_en` bits asserted.
- R9: A write to `cfg_addr` = 8 clears the total. Refreshes issued on that same edge are counted starting from zero.
- R10: `refresh_total` saturates at all ones and stays there until it is cleared.
- R11: `cfg_rdata` returns the following, with no delay:
  - the zero-extended multiplier for addresses 0..7;
  - the total for address 8;
  - zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_pulse | input | 1 | One base refresh command from the scheduler |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: 0..7 plane multipliers, 8 refresh total |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | TOTAL_W (32) | Combinational read data for `cfg_addr` |
| refresh_en | output | 8 | Per-plane refresh enable, bit i = plane i |
| refresh_total | output | TOTAL_W (32) | Saturating count of issued per-plane refreshes |

## Verification
The bound checker checks these properties on every cycle:
- enables appear only after a sampled base pulse;
- a stored multiplier is never zero;
- the total grows by exactly the number of enables;
- a clear restarts the total from the enables of that edge;
- a saturated total holds.

Some behaviours need the bench's scenarios to show them, because they depend on sequences of pulses:
- the refresh rate over a long run, ceil(N/k) for each plane;
- the all-plane refresh on the first pulse;
- the deferral of a new multiplier until the running countdown ends;
- reaching saturation.

The bench's cycle model is compared against every output on every clock.

// File: rtl/refresh_gater_pkg.sv
// Package: shared constants and types for the bit-plane refresh gater.
// Assumes one plane per bit of the stored word; widths are defaults only.
package refresh_gater_pkg;
    parameter int DEF_PLANES  = 8;
    parameter int DEF_MULT_W  = 8;
    parameter int DEF_TOTAL_W = 32;
endpackage

// File: rtl/plane_timer.sv
// Module: one bit plane's refresh divider.
// Holds the plane's multiplier and a countdown. On a base pulse with the
// countdown at 1 it fires and reloads from the multiplier; otherwise it
// decrements. A zero write is rejected. A new multiplier is only seen at the
// next reload. Assumes base_pulse is a single-cycle strobe per base period.
module plane_timer #(
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_pulse,
    input  logic              wr_en,
    input  logic [MULT_W-1:0] wr_data,
    output logic              fire,
    output logic [MULT_W-1:0] mult_o
);
    localparam logic [MULT_W-1:0] ONE = MULT_W'(1);

    logic [MULT_W-1:0] mult_q;
    logic [MULT_W-1:0] cnt_q;

    // Fire when a pulse meets an expired countdown.
    assign fire   = base_pulse && (cnt_q == ONE);
    assign mult_o = mult_q;

    // Multiplier register: accepts nonzero writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= ONE;
        end else if (wr_en && (wr_data != '0)) begin
            mult_q <= wr_data;
        end
    end

    // Countdown: reload on fire, decrement on any other pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (base_pulse) begin
            if (cnt_q == ONE) begin
                cnt_q <= mult_q;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end
endmodule

// File: rtl/refresh_tally.sv
// Module: saturating accumulator of issued per-plane refreshes.
// Adds the number of set fire bits each cycle and sticks at all ones.
// A clear restarts the count from this cycle's fire bits.
module refresh_tally #(
    parameter int LANES   = 8,
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   fire,
    input  logic               clr,
    output logic [TOTAL_W-1:0] total
);
    localparam int CW = $clog2(LANES + 1);
    localparam logic [TOTAL_W-1:0] MAXV = '1;

    logic [CW-1:0]      pop;
    logic [TOTAL_W:0]   sum_ext;
    logic [TOTAL_W-1:0] total_q;

    // Population count of this cycle's fire bits.
    always_comb begin
        pop = '0;
        for (int i = 0; i < LANES; i++) begin
            pop = pop + CW'(fire[i]);
        end
    end

    // Widened sum so the carry out shows overflow.
    assign sum_ext = {1'b0, total_q} + {{(TOTAL_W + 1 - CW){1'b0}}, pop};

    // Accumulate, saturate or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clr) begin
            total_q <= {{(TOTAL_W - CW){1'b0}}, pop};
        end else if (sum_ext[TOTAL_W]) begin
            total_q <= MAXV;
        end else begin
            total_q <= sum_ext[TOTAL_W-1:0];
        end
    end

    assign total = total_q;
endmodule

// File: rtl/refresh_plane_gater.sv
// Module: top of the per-bit-plane refresh gater.
// Replicates one plane_timer per bit plane, registers the enables, keeps the
// refresh tally and decodes the register port (0..PLANES-1 multipliers,
// PLANES = total, write there clears it). Assumes a single-cycle base_pulse.
module refresh_plane_gater #(
    parameter int PLANES  = refresh_gater_pkg::DEF_PLANES,
    parameter int MULT_W  = refresh_gater_pkg::DEF_MULT_W,
    parameter int TOTAL_W = refresh_gater_pkg::DEF_TOTAL_W,
    localparam int ADDR_W = $clog2(PLANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_pulse,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [MULT_W-1:0]  cfg_wdata,
    output logic [TOTAL_W-1:0] cfg_rdata,
    output logic [PLANES-1:0]  refresh_en,
    output logic [TOTAL_W-1:0] refresh_total
);
    localparam logic [ADDR_W-1:0] ADDR_TOTAL = ADDR_W'(PLANES);

    logic [PLANES-1:0] fire;
    logic [MULT_W-1:0] mult_arr [PLANES];
    logic [PLANES-1:0] en_q;
    logic              tally_clr;

    // One divider per bit plane.
    for (genvar g = 0; g < PLANES; g++) begin : g_plane
        plane_timer #(.MULT_W(MULT_W)) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .base_pulse (base_pulse),
            .wr_en      (cfg_wr && (cfg_addr == ADDR_W'(g))),
            .wr_data    (cfg_wdata),
            .fire       (fire[g]),
            .mult_o     (mult_arr[g])
        );
    end

    // Register the enables so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= fire;
        end
    end

    assign tally_clr = cfg_wr && (cfg_addr == ADDR_TOTAL);

    refresh_tally #(.LANES(PLANES), .TOTAL_W(TOTAL_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .clr   (tally_clr),
        .total (refresh_total)
    );

    // Read mux over multipliers and total.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < PLANES; i++) begin
            if (cfg_addr == ADDR_W'(i)) begin
                cfg_rdata = {{(TOTAL_W - MULT_W){1'b0}}, mult_arr[i]};
            end
        end
        if (cfg_addr == ADDR_TOTAL) begin
            cfg_rdata = refresh_total;
        end
    end

    assign refresh_en = en_q;
endmodule

// File: rtl/refresh_gater_chk.sv
// Module: property checker bound to refresh_plane_gater. Observes ports only.
module refresh_gater_chk #(
    parameter int PLANES  = 8,
    parameter int TOTAL_W = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               base_pulse,
    input logic               cfg_wr,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [TOTAL_W-1:0] cfg_rdata,
    input logic [PLANES-1:0]  refresh_en,
    input logic [TOTAL_W-1:0] refresh_total
);
    localparam logic [TOTAL_W-1:0] MAXV = '1;
    localparam logic [TOTAL_W-1:0] HEADROOM = MAXV - TOTAL_W'(PLANES);

    logic clr;
    assign clr = cfg_wr && (cfg_addr == ADDR_W'(PLANES));

    // R4
    en_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_en != '0) |-> $past(base_pulse));

    // R6
    mult_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr < ADDR_W'(PLANES)) |-> (cfg_rdata != '0));

    // R8
    total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && ($past(refresh_total) <= HEADROOM)) |->
        (refresh_total == $past(refresh_total) + TOTAL_W'($countones(refresh_en))));

    // R9
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (refresh_total == TOTAL_W'($countones(refresh_en))));

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && ($past(refresh_total) == MAXV)) |-> (refresh_total == MAXV));
endmodule

bind refresh_plane_gater refresh_gater_chk #(
    .PLANES(PLANES), .TOTAL_W(TOTAL_W), .ADDR_W(ADDR_W)
) u_gater_chk (
    .clk(clk), .rst_n(rst_n), .base_pulse(base_pulse), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .refresh_en(refresh_en),
    .refresh_total(refresh_total)
);

// File: tb/test_refresh_plane_gater.sv
module test_refresh_plane_gater;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int TW = 12;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_pulse = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [TW-1:0] cfg_rdata;
    logic [NP-1:0] refresh_en;
    logic [TW-1:0] refresh_total;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    refresh_plane_gater #(.PLANES(NP), .MULT_W(8), .TOTAL_W(TW)) i_refresh_plane_gater (
        .clk(clk), .rst_n(rst_n), .base_pulse(base_pulse), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .refresh_en(refresh_en), .refresh_total(refresh_total)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference model.
    int m_mult [NP];
    int m_cnt [NP];
    int m_en [NP];
    int m_total = 0;
    bit live = 0;

    always @(posedge clk) begin
        int pop;
        live = 1;
        if (!rst_n) begin
            foreach (m_mult[i]) begin m_mult[i] = 1; m_cnt[i] = 1; m_en[i] = 0; end
            m_total = 0;
        end else begin
            pop = 0;
            for (int i = 0; i < NP; i++) begin
                m_en[i] = 0;
                if (base_pulse) begin
                    if (m_cnt[i] == 1) begin
                        m_en[i] = 1; pop++; m_cnt[i] = m_mult[i];
                    end else begin
                        m_cnt[i]--;
                    end
                end
                if (cfg_wr && cfg_addr == i && cfg_wdata != 0) m_mult[i] = cfg_wdata;
            end
            if (cfg_wr && cfg_addr == NP) m_total = pop;
            else m_total = (m_total + pop > TMAX) ? TMAX : m_total + pop;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (live && !done) begin
            int exp_rd;
            for (int i = 0; i < NP; i++) check("R4 enable per plane", refresh_en[i], m_en[i]);
            check("R8 total", refresh_total, m_total);
            if (cfg_addr < NP) exp_rd = m_mult[cfg_addr];
            else if (cfg_addr == NP) exp_rd = m_total;
            else exp_rd = 0;
            check("R11 read data", cfg_rdata, exp_rd);
        end
    end

    // Long-run fire counters.
    int fire_cnt [NP];
    bit counting = 0;
    always @(negedge clk) begin
        if (counting) for (int i = 0; i < NP; i++) fire_cnt[i] += refresh_en[i];
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; base_pulse = 0; cfg_wr = 0;
        repeat (3) tick();
        rst_n = 1;
    endtask

    task automatic wr(int a, int d);
        cfg_wr = 1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        tick();
        cfg_wr = 0;
    endtask

    task automatic pulse(output logic [NP-1:0] e);
        base_pulse = 1;
        tick();
        base_pulse = 0;
        @(negedge clk);
        e = refresh_en;
        tick();
    endtask

    task automatic read_chk(string req, int a, int exp);
        cfg_addr = 4'(a);
        @(negedge clk);
        check(req, cfg_rdata, exp);
        tick();
    endtask

    initial begin
        logic [NP-1:0] e;
        logic [NP-1:0] seq [6];
        int ks [NP] = '{8, 6, 4, 3, 2, 2, 1, 1};
        do_reset();
        @(negedge clk);
        check("R1 enables after reset", refresh_en, 0);
        check("R1 total after reset", refresh_total, 0);
        tick();
        for (int i = 0; i < NP; i++) read_chk("R1 multiplier default", i, 1);

        pulse(e);
        check("R2 first pulse all planes", e, 8'hFF);
        check("R8 total after first pulse", refresh_total, 8);
        @(negedge clk);
        check("R4 enable one cycle wide", refresh_en, 0);
        tick();

        // R5 / R6: program ramp, try a zero write.
        do_reset();
        for (int i = 0; i < NP; i++) wr(i, ks[i]);
        wr(2, 0);
        read_chk("R6 zero write ignored", 2, 4);
        read_chk("R5 multiplier stored plane 0", 0, 8);
        read_chk("R5 multiplier stored plane 7", 7, 1);

        // R3: 48 pulses from reset phase.
        foreach (fire_cnt[i]) fire_cnt[i] = 0;
        counting = 1;
        for (int p = 0; p < 48; p++) pulse(e);
        repeat (2) tick();
        counting = 0;
        for (int i = 0; i < NP; i++) check("R3 refresh count", fire_cnt[i], (48 + ks[i] - 1) / ks[i]);

        // R7: change multiplier mid-countdown.
        do_reset();
        wr(0, 4);
        pulse(e);
        pulse(e);
        wr(0, 2);
        for (int p = 0; p < 5; p++) pulse(seq[p]);
        check("R7 old countdown pulse 1", seq[0][0], 0);
        check("R7 old countdown pulse 2", seq[1][0], 0);
        check("R7 old countdown completes", seq[2][0], 1);
        check("R7 new value after reload", seq[3][0], 0);
        check("R7 new interval fires", seq[4][0], 1);

        // R9: clear alone and clear with concurrent refreshes.
        wr(NP, 0);
        @(negedge clk);
        check("R9 clear alone", refresh_total, 0);
        tick();
        do_reset();
        cfg_wr = 1; cfg_addr = 4'(NP); base_pulse = 1;
        tick();
        cfg_wr = 0; base_pulse = 0;
        @(negedge clk);
        check("R9 clear counts same edge", refresh_total, 8);
        tick();

        // R10: saturate with continuous pulses.
        base_pulse = 1;
        repeat (520) tick();
        base_pulse = 0;
        @(negedge clk);
        check("R10 saturated", refresh_total, TMAX);
        tick();
        read_chk("R11 total readback", NP, TMAX);
        read_chk("R11 unused address", 9, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule